// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Master

This block reads a single byte from a two-wire serial EEPROM at a 16-bit word address. It drives the bus clock, a data value and a data output enable as three separate pins and samples the data line on its own input pin. The external pad or pull-up logic merges the value and enable pins into the shared wire. The block has no open-drain line of its own.

A request is a one-cycle `start_i` pulse with `addr_i` valid in that cycle. The block raises `busy_o` and performs the random-read transaction. That transaction is a start, a dummy write of the device byte 0xA0, the address high byte and the address low byte, then a repeated start, the device byte 0xA1, eight data bits, and a stop. Every acknowledge is checked. A missing acknowledge abandons the transfer and goes straight to the stop. Each pin-level step lasts `STEP_CYCLES` clock cycles, so the step time is set by that count (about 1 us in the target use).

The request side is plain control and has no back-pressure. `busy_o` low is the only ready condition, and a `start_i` seen while busy is dropped. The result is a one-cycle `done_o` pulse that the consumer must capture; it cannot stall it. A station address of six bytes can be read from locations 0x008E to 0x0093 with six back-to-back requests.

Top module: `eep_rand_reader`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `done_o`, `err_o`, `scl_o`, `sda_o` and `sda_oe_o` are 0 and `rdata_o` is 0x00.
- R2: A start condition is the step sequence: data high, enable on, clock high, data low, clock low.
- R3: A byte is sent MSB first. First data is set low and the enable is turned on. Then each bit takes three steps: data set to the bit, clock high, clock low.
- R4: After each sent byte the acknowledge takes four steps: data low, enable off, clock high, clock low. The data input is sampled on the last clock cycle of the clock-high step, and the enable is off whenever the data input is sampled.
- R5: The sent bytes are, in this order: 0xA0, `addr_i[15:8]`, `addr_i[7:0]`, then a repeated start (as in R2), then 0xA1.
- R6: After the 0xA1 acknowledge, eight bits are read MSB first. Each bit is a clock-high step, sampled on its last cycle, followed by a clock-low step. No acknowledge is driven, and `rdata_o` holds the byte at completion.
- R7: A stop condition is the step sequence: data low, enable on, clock high, data high, clock low. A stop ends every transfer, including an aborted one, and the pins then hold their last values while idle.
- R8: A 1 sampled as the acknowledge of any sent byte skips every later byte, goes directly to the stop, and ends with `err_o`=1 and `rdata_o`=0x00. A full transfer ends with `err_o`=0.
- R9: Each step holds its pin values for exactly `STEP_CYCLES` cycles. The first step appears in the cycle after `start_i` is accepted.
- R10: In the cycle after the last stop step ends, `done_o` is 1 for exactly one cycle and `busy_o` is 0 in that same cycle.
- R11: `start_i` while `busy_o` is 1 is ignored, including in the final cycle of the stop, and the transfer under way is unaffected.
- R12: `start_i` in the cycle where `done_o` is 1 is accepted, giving back-to-back transfers with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a read (taken only when idle) |
| addr_i | input | 16 | EEPROM word address, sampled with an accepted request |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte read, valid with `done_o` |
| err_o | output | 1 | Missing acknowledge, valid with `done_o` |
| scl_o | output | 1 | Bus clock |
| sda_o | output | 1 | Data value to drive |
| sda_oe_o | output | 1 | Data output enable |
| sda_i | input | 1 | Sampled data line |

## Verification
Two functions share cycles: the request port and the sequencer's completion. A new `start_i` can land on the edge that ends the final stop step, or in the `done_o` cycle. The bench raises `start_i` in the last cycle of a stop step and in the completion cycle. It expects the first to leave `busy_o` low afterwards and the second to begin a new transfer whose first step matches the reference model on the very next cycle. A request in the middle of a transfer, carrying a different address, is also judged by the per-cycle pin comparison against the model of the original address.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SUB_W  = 4;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] DEV_WR = 8'hA0;
  localparam logic [BYTE_W-1:0] DEV_RD = 8'hA1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_WBYTE,
    PH_RBYTE,
    PH_STOP
  } phase_e;

  typedef enum logic [2:0] {
    OP_SCL_HI,
    OP_SCL_LO,
    OP_SDA_HI,
    OP_SDA_LO,
    OP_OE_HI,
    OP_OE_LO,
    OP_SDA_TX
  } pin_op_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic oe;
  } pins_t;

  // pin operation performed on entry to a given step
  function automatic pin_op_e step_op(phase_e ph, logic [SUB_W-1:0] sub);
    pin_op_e op;
    op = OP_SCL_LO;
    case (ph)
      PH_START: begin
        case (sub)
          4'd0:    op = OP_SDA_HI;
          4'd1:    op = OP_OE_HI;
          4'd2:    op = OP_SCL_HI;
          4'd3:    op = OP_SDA_LO;
          default: op = OP_SCL_LO;
        endcase
      end
      PH_WBYTE: begin
        case (sub)
          4'd0:    op = OP_SDA_LO;
          4'd1:    op = OP_OE_HI;
          4'd2:    op = OP_SDA_TX;
          4'd3:    op = OP_SCL_HI;
          4'd4:    op = OP_SCL_LO;
          4'd5:    op = OP_SDA_LO;
          4'd6:    op = OP_OE_LO;
          4'd7:    op = OP_SCL_HI;
          default: op = OP_SCL_LO;
        endcase
      end
      PH_RBYTE: op = (sub == 4'd0) ? OP_SCL_HI : OP_SCL_LO;
      PH_STOP: begin
        case (sub)
          4'd0:    op = OP_SDA_LO;
          4'd1:    op = OP_OE_HI;
          4'd2:    op = OP_SCL_HI;
          4'd3:    op = OP_SDA_HI;
          default: op = OP_SCL_LO;
        endcase
      end
      default: op = OP_SCL_LO;
    endcase
    return op;
  endfunction

  // steps whose last cycle samples the data input
  function automatic logic step_samples(phase_e ph, logic [SUB_W-1:0] sub);
    return ((ph == PH_WBYTE) && (sub == 4'd7)) ||
           ((ph == PH_RBYTE) && (sub == 4'd0));
  endfunction

  function automatic pins_t apply_op(pins_t p, pin_op_e op, logic txb);
    pins_t r;
    r = p;
    case (op)
      OP_SCL_HI: r.scl = 1'b1;
      OP_SCL_LO: r.scl = 1'b0;
      OP_SDA_HI: r.sda = 1'b1;
      OP_SDA_LO: r.sda = 1'b0;
      OP_OE_HI:  r.oe  = 1'b1;
      OP_OE_LO:  r.oe  = 1'b0;
      OP_SDA_TX: r.sda = txb;
      default:   r = p;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eep_step_timer.sv
module eep_step_timer #(
  parameter int unsigned STEP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);

  localparam int unsigned CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/eep_step_seq.sv
module eep_step_seq
  import eep_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sda_i,
  output pin_op_e           op_o,
  output logic              txbit_o,
  output logic              samp_o,
  output logic              fin_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              nack_o
);

  phase_e            ph_q, n_ph;
  logic [SUB_W-1:0]  sub_q, n_sub;
  logic [BIT_W-1:0]  bit_q, n_bit;
  logic [1:0]        idx_q, n_idx;
  logic              ack_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_n;

  function automatic logic [BYTE_W-1:0] tx_byte(logic [1:0] i, logic [ADDR_W-1:0] a);
    case (i)
      2'd0:    return DEV_WR;
      2'd1:    return a[ADDR_W-1 -: BYTE_W];
      2'd2:    return a[BYTE_W-1:0];
      default: return DEV_RD;
    endcase
  endfunction

  always_comb begin
    n_ph  = ph_q;
    n_sub = sub_q;
    n_bit = bit_q;
    n_idx = idx_q;
    fin_o = 1'b0;
    if (kick_i) begin
      n_ph  = PH_START;
      n_sub = '0;
      n_idx = 2'd0;
      n_bit = BIT_W'(BYTE_W - 1);
    end else if (adv_i) begin
      unique case (ph_q)
        PH_START: begin
          if (sub_q == 4'd4) begin
            n_ph  = PH_WBYTE;
            n_sub = '0;
            n_bit = BIT_W'(BYTE_W - 1);
          end else begin
            n_sub = sub_q + 4'd1;
          end
        end
        PH_WBYTE: begin
          case (sub_q)
            4'd4: begin
              if (bit_q == '0) begin
                n_sub = 4'd5;
              end else begin
                n_sub = 4'd2;
                n_bit = bit_q - 1'b1;
              end
            end
            4'd8: begin
              n_sub = '0;
              n_bit = BIT_W'(BYTE_W - 1);
              if (ack_q) begin
                n_ph = PH_STOP;
              end else if (idx_q == 2'd2) begin
                n_ph  = PH_START;
                n_idx = 2'd3;
              end else if (idx_q == 2'd3) begin
                n_ph = PH_RBYTE;
              end else begin
                n_idx = idx_q + 2'd1;
              end
            end
            default: n_sub = sub_q + 4'd1;
          endcase
        end
        PH_RBYTE: begin
          if (sub_q == 4'd1) begin
            n_sub = '0;
            if (bit_q == '0) begin
              n_ph = PH_STOP;
            end else begin
              n_bit = bit_q - 1'b1;
            end
          end else begin
            n_sub = 4'd1;
          end
        end
        PH_STOP: begin
          if (sub_q == 4'd4) begin
            n_ph  = PH_IDLE;
            n_sub = '0;
            fin_o = 1'b1;
          end else begin
            n_sub = sub_q + 4'd1;
          end
        end
        default: begin
          n_ph  = PH_IDLE;
          n_sub = '0;
        end
      endcase
    end
  end

  assign tx_n    = tx_byte(n_idx, addr_i);
  assign txbit_o = tx_n[n_bit];
  assign op_o    = step_op(n_ph, n_sub);
  assign samp_o  = adv_i & step_samples(ph_q, sub_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      idx_q <= '0;
      ack_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      ph_q  <= n_ph;
      sub_q <= n_sub;
      bit_q <= n_bit;
      idx_q <= n_idx;
      if (kick_i) begin
        ack_q <= 1'b0;
        rx_q  <= '0;
      end else if (samp_o) begin
        if (ph_q == PH_WBYTE) ack_q <= sda_i;
        else                  rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
      end
    end
  end

  assign rx_o   = rx_q;
  assign nack_o = ack_q;

  // a missing acknowledge leads straight into the stop
  assert_stop_after_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && ph_q == PH_WBYTE && sub_q == 4'd8 && ack_q) |=> (ph_q == PH_STOP && sub_q == '0));

endmodule

// File: rtl/eep_pin_drv.sv
module eep_pin_drv
  import eep_rd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  pin_op_e op_i,
  input  logic    txbit_i,
  output logic    scl_o,
  output logic    sda_o,
  output logic    oe_o
);

  pins_t pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
    end else if (load_i) begin
      pins_q <= apply_op(pins_q, op_i, txbit_i);
    end
  end

  assign scl_o = pins_q.scl;
  assign sda_o = pins_q.sda;
  assign oe_o  = pins_q.oe;

endmodule

// File: rtl/eep_rand_reader.sv
module eep_rand_reader
  import eep_rd_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              err_o,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, adv, expire, fin, load_pins, samp, txbit_n, nack;
  pin_op_e           op_n;
  logic [BYTE_W-1:0] rx;

  assign accept    = start_i & ~busy_q;
  assign adv       = busy_q & expire;
  assign load_pins = accept | (adv & ~fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        addr_q <= addr_i;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  eep_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_pins),
    .expire_o (expire)
  );

  eep_step_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick_i  (accept),
    .adv_i   (adv),
    .addr_i  (addr_q),
    .sda_i   (sda_i),
    .op_o    (op_n),
    .txbit_o (txbit_n),
    .samp_o  (samp),
    .fin_o   (fin),
    .rx_o    (rx),
    .nack_o  (nack)
  );

  eep_pin_drv u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_pins),
    .op_i    (op_n),
    .txbit_i (txbit_n),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .oe_o    (sda_oe_o)
  );

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rx;
  assign err_o   = nack;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_step_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !expire) |=> ($stable(scl_o) && $stable(sda_o) && $stable(sda_oe_o)));

  assert_sample_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> !sda_oe_o);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> (addr_q == $past(addr_q)));

endmodule

// File: tb/eep_rand_reader_bench.sv
module eep_rand_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        sda_i = 1'b1;
  logic        busy_o, done_o, err_o, scl_o, sda_o, sda_oe_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed { bit scl; bit sda; bit oe; bit din; } step_t;
  step_t sq[$];
  string tq[$];
  bit m_scl, m_sda, m_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_rand_reader #(.STEP_CYCLES(STEP)) u_eep_rand_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
    .scl_o(scl_o), .sda_o(sda_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_of(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic push(string tag, bit din);
    sq.push_back('{m_scl, m_sda, m_oe, din});
    tq.push_back(tag);
  endtask

  task automatic emit_start();
    m_sda = 1; push("R2", 1);
    m_oe  = 1; push("R2", 1);
    m_scl = 1; push("R2", 1);
    m_sda = 0; push("R2", 1);
    m_scl = 0; push("R2", 1);
  endtask

  task automatic emit_stop();
    m_sda = 0; push("R7", 1);
    m_oe  = 1; push("R7", 1);
    m_scl = 1; push("R7", 1);
    m_sda = 1; push("R7", 1);
    m_scl = 0; push("R7", 1);
  endtask

  task automatic emit_wbyte(logic [7:0] v, bit nack);
    m_sda = 0; push("R3", 1);
    m_oe  = 1; push("R3", 1);
    for (int i = 7; i >= 0; i--) begin
      m_sda = v[i]; push("R3 R5", 1);
      m_scl = 1;    push("R3", 1);
      m_scl = 0;    push("R3", 1);
    end
    m_sda = 0; push("R4", 1);
    m_oe  = 0; push("R4", 1);
    m_scl = 1; push("R4", nack);
    m_scl = 0; push("R4", 1);
  endtask

  task automatic build(logic [15:0] a, int nack_at);
    logic [7:0] v;
    logic [7:0] d;
    sq.delete();
    tq.delete();
    emit_start();
    for (int b = 0; b < 4; b++) begin
      if (b == 3) emit_start();
      case (b)
        0:       v = 8'hA0;
        1:       v = a[15:8];
        2:       v = a[7:0];
        default: v = 8'hA1;
      endcase
      emit_wbyte(v, nack_at == b);
      if (nack_at == b) begin
        emit_stop();
        return;
      end
    end
    d = rom_of(a);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1; push("R6", d[i]);
      m_scl = 0; push("R6", 1);
    end
    emit_stop();
  endtask

  // entered at a negedge where start_i was just raised for address a
  task automatic run_txn(logic [15:0] a, int nack_at, bit inj_mid, bit inj_end,
                         bit chain, logic [15:0] next_a);
    logic [4:0] got, exp;
    int n;
    build(a, nack_at);
    n = sq.size();
    @(negedge clk);
    start_i = 0;
    for (int s = 0; s < n; s++) begin
      for (int c = 0; c < STEP; c++) begin
        sda_i = sq[s].din;
        got = {scl_o, sda_o, sda_oe_o, busy_o, done_o};
        exp = {sq[s].scl, sq[s].sda, sq[s].oe, 1'b1, 1'b0};
        chk(got == exp, {tq[s], " R9 R11 R12"}, "scl/sda/oe/busy/done", int'(got), int'(exp));
        if (inj_mid && s == 40 && c == 1) begin
          start_i = 1; addr_i = ~a;
        end else if (inj_end && s == n - 1 && c == STEP - 1) begin
          start_i = 1; addr_i = ~a;
        end else begin
          start_i = 0;
        end
        @(negedge clk);
      end
    end
    chk(done_o && !busy_o, "R10", "done/busy at completion", int'({done_o, busy_o}), 2'b10);
    chk(rdata_o == ((nack_at >= 0) ? 8'h00 : rom_of(a)), "R6 R8", "rdata",
        int'(rdata_o), int'((nack_at >= 0) ? 8'h00 : rom_of(a)));
    chk(err_o == (nack_at >= 0), "R8", "err", int'(err_o), int'(nack_at >= 0));
    sda_i = 1;
    if (chain) begin
      start_i = 1; addr_i = next_a;
    end else begin
      start_i = 0;
      @(negedge clk);
      chk(!done_o && !busy_o, "R10 R11", "done/busy after completion",
          int'({done_o, busy_o}), 0);
      chk({scl_o, sda_o, sda_oe_o} == 3'b011, "R7", "idle pins",
          int'({scl_o, sda_o, sda_oe_o}), 3'b011);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: done seen=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_scl = 0; m_sda = 0; m_oe = 0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, scl_o, sda_o, sda_oe_o} == 6'b0 && rdata_o == 8'h00,
        "R1", "outputs in reset", int'({busy_o, done_o, err_o, scl_o, sda_o, sda_oe_o}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({busy_o, done_o, err_o, scl_o, sda_o, sda_oe_o} == 6'b0 && rdata_o == 8'h00,
        "R1", "outputs after reset", int'({busy_o, done_o, err_o, scl_o, sda_o, sda_oe_o}), 0);

    // station address block, back-to-back (R12), with start collisions (R11)
    start_i = 1; addr_i = 16'h008E;
    run_txn(16'h008E, -1, 0, 0, 1, 16'h008F);
    run_txn(16'h008F, -1, 1, 0, 1, 16'h0090);
    run_txn(16'h0090, -1, 0, 1, 1, 16'h0091);
    run_txn(16'h0091, -1, 0, 0, 1, 16'h0092);
    run_txn(16'h0092, -1, 0, 0, 1, 16'h0093);
    run_txn(16'h0093, -1, 0, 1, 0, 16'h0000);

    // missing acknowledge on each sent byte (R8, R7)
    for (int nb = 0; nb < 4; nb++) begin
      @(negedge clk);
      start_i = 1; addr_i = 16'hA55A;
      run_txn(16'hA55A, nb, 0, 0, 0, 16'h0000);
    end

    // corner addresses (R5)
    @(negedge clk);
    start_i = 1; addr_i = 16'hFFFF;
    run_txn(16'hFFFF, -1, 0, 0, 0, 16'h0000);
    @(negedge clk);
    start_i = 1; addr_i = 16'h0000;
    run_txn(16'h0000, -1, 1, 0, 0, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule